// File: doc/BRIEF.md
# Bit-Slice ALU with Operand Select

This block is the combinational arithmetic and logic stage of a microprogrammed datapath. Four data words feed it: two register-file read ports (A and B), the working Q register, and a direct data input D. A 3-bit source code chooses which pair of them, or zero in their place, becomes the two ALU operands R and S. A 3-bit function code then applies one of three carry-aware arithmetic forms or one of five logic forms.

The stage produces the result word and four flags: carry-out, sign, zero and two's complement overflow. The surrounding datapath keeps the registers, does the shifting and drives the output bus. It picks up the result and the flags in the same cycle the operands are presented.

The word width is the parameter `WIDTH`, which defaults to 32.

Top module: `bitslice_alu`

## Requirements
- R1: `src_sel` picks the operand pair (R, S) as follows: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R2: `fn_sel`=0 gives R + S + `carry_in`, taken modulo 2^WIDTH.
- R3: `fn_sel`=1 gives S + ~R + `carry_in`. With `carry_in`=1 this is S − R; with `carry_in`=0 it is one less.
- R4: `fn_sel`=2 gives R + ~S + `carry_in`.
- R5: `fn_sel` 3..7 give R|S, R&S, ~R&S, R^S and ~(R^S), in that order. `carry_in` has no effect on these codes.
- R6: `sign` always equals the most significant result bit.
- R7: `zero` is high exactly when every result bit is 0.
- R8: For `fn_sel` 0..2, `overflow` is high exactly when the two added terms have the same top bit and the result's top bit differs from it.
- R9: For `fn_sel` 0..2, `carry_out` is the carry out of the most significant bit of the addition.
- R10: For `fn_sel` 3..7, `carry_out` and `overflow` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_port | input | WIDTH | First register-file read word |
| b_port | input | WIDTH | Second register-file read word |
| q_reg | input | WIDTH | Working register word |
| d_in | input | WIDTH | Direct data word |
| src_sel | input | 3 | Operand pair select |
| fn_sel | input | 3 | Operation select |
| carry_in | input | 1 | Carry into the low bit for arithmetic codes |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top bit |
| sign | output | 1 | Top bit of the result |
| zero | output | 1 | High when the result is all zero |
| overflow | output | 1 | Signed overflow of an arithmetic code |

## Verification
The bench builds one instance with WIDTH=4. This size makes a complete sweep reachable: every source code, every function code, both carry-in values and all 256 combinations of the two operand values. As a result, every flag condition, including each signed overflow case and each carry case, is hit. A second instance at the default WIDTH=32 is driven with directed words at the signed and unsigned boundaries, which confirms that the carry chain and flags scale to the full word.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_port,
  input  logic [WIDTH-1:0] b_port,
  input  logic [WIDTH-1:0] q_reg,
  input  logic [WIDTH-1:0] d_in,
  input  logic [2:0]       src_sel,
  input  logic [2:0]       fn_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             sign,
  output logic             zero,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] r_op, s_op, x_op, y_op, logic_res, arith_res;
  logic [MSB:0]     low_sum;
  logic             c_into_msb, c_from_msb, is_arith;

  always_comb begin
    r_op = '0;
    s_op = '0;
    case (src_sel)
      3'd0: begin r_op = a_port; s_op = q_reg;  end
      3'd1: begin r_op = a_port; s_op = b_port; end
      3'd2: begin r_op = '0;     s_op = q_reg;  end
      3'd3: begin r_op = '0;     s_op = b_port; end
      3'd4: begin r_op = '0;     s_op = a_port; end
      3'd5: begin r_op = d_in;   s_op = a_port; end
      3'd6: begin r_op = d_in;   s_op = q_reg;  end
      default: begin r_op = d_in; s_op = '0;    end
    endcase
  end

  always_comb begin
    case (fn_sel)
      3'd1:    begin x_op = s_op; y_op = ~r_op; end
      3'd2:    begin x_op = r_op; y_op = ~s_op; end
      default: begin x_op = r_op; y_op = s_op;  end
    endcase
  end

  assign is_arith   = (fn_sel < 3'd3);
  assign low_sum    = {1'b0, x_op[MSB-1:0]} + {1'b0, y_op[MSB-1:0]} + {{MSB{1'b0}}, carry_in};
  assign c_into_msb = low_sum[MSB];
  assign c_from_msb = (x_op[MSB] & y_op[MSB]) | (c_into_msb & (x_op[MSB] ^ y_op[MSB]));
  assign arith_res  = {x_op[MSB] ^ y_op[MSB] ^ c_into_msb, low_sum[MSB-1:0]};

  always_comb begin
    case (fn_sel)
      3'd3:    logic_res = r_op | s_op;
      3'd4:    logic_res = r_op & s_op;
      3'd5:    logic_res = ~r_op & s_op;
      3'd6:    logic_res = r_op ^ s_op;
      default: logic_res = ~(r_op ^ s_op);
    endcase
  end

  assign result    = is_arith ? arith_res : logic_res;
  assign carry_out = is_arith & c_from_msb;
  assign overflow  = is_arith & (c_from_msb ^ c_into_msb);
  assign sign      = result[MSB];
  assign zero      = ~|result;
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_port,
  input logic [WIDTH-1:0] b_port,
  input logic [WIDTH-1:0] q_reg,
  input logic [WIDTH-1:0] d_in,
  input logic [2:0]       src_sel,
  input logic [2:0]       fn_sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             sign,
  input logic             zero,
  input logic             overflow
);
  logic [WIDTH-1:0] rr, ss;
  logic [WIDTH:0]   add_sum, subr_sum, subs_sum, cin_ext;

  always_comb begin
    rr = (src_sel == 3'd0 || src_sel == 3'd1) ? a_port :
         (src_sel >= 3'd5) ? d_in : '0;
    ss = (src_sel == 3'd1 || src_sel == 3'd3) ? b_port :
         (src_sel == 3'd4 || src_sel == 3'd5) ? a_port :
         (src_sel == 3'd7) ? '0 : q_reg;
    cin_ext  = {{WIDTH{1'b0}}, carry_in};
    add_sum  = {1'b0, rr} + {1'b0, ss} + cin_ext;
    subr_sum = {1'b0, ss} + {1'b0, ~rr} + cin_ext;
    subs_sum = {1'b0, rr} + {1'b0, ~ss} + cin_ext;
    if (fn_sel == 3'd0)
      a_r2_add: assert ({carry_out, result} == add_sum) else $error("a_r2_add");
    if (fn_sel == 3'd1)
      a_r3_subr: assert ({carry_out, result} == subr_sum) else $error("a_r3_subr");
    if (fn_sel == 3'd2)
      a_r4_subs: assert ({carry_out, result} == subs_sum) else $error("a_r4_subs");
    if (fn_sel == 3'd0)
      a_r8_add_overflow: assert (overflow == ((rr[WIDTH-1] == ss[WIDTH-1]) && (result[WIDTH-1] != rr[WIDTH-1])))
        else $error("a_r8_add_overflow");
    if (fn_sel >= 3'd3)
      a_r10_logic_flags: assert (!carry_out && !overflow) else $error("a_r10_logic_flags");
    a_r7_zero_sign: assert (!(zero && sign)) else $error("a_r7_zero_sign");
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_port(a_port), .b_port(b_port), .q_reg(q_reg), .d_in(d_in),
  .src_sel(src_sel), .fn_sel(fn_sel), .carry_in(carry_in),
  .result(result), .carry_out(carry_out), .sign(sign),
  .zero(zero), .overflow(overflow)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [3:0] a4, b4, q4, d4, res4;
  logic [2:0] src, fn;
  logic       cin, co4, sg4, zr4, ov4;

  logic [31:0] a32, b32, q32, d32, res32;
  logic [2:0]  src32, fn32;
  logic        cin32, co32, sg32, zr32, ov32;

  bitslice_alu #(.WIDTH(4)) u_dut (
    .a_port(a4), .b_port(b4), .q_reg(q4), .d_in(d4),
    .src_sel(src), .fn_sel(fn), .carry_in(cin),
    .result(res4), .carry_out(co4), .sign(sg4), .zero(zr4), .overflow(ov4));

  bitslice_alu u_dut32 (
    .a_port(a32), .b_port(b32), .q_reg(q32), .d_in(d32),
    .src_sel(src32), .fn_sel(fn32), .carry_in(cin32),
    .result(res32), .carry_out(co32), .sign(sg32), .zero(zr32), .overflow(ov32));

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model4(int s_code, int f_code, int c, int x, int y);
    int r, s, xo, yo, tot, res, co, ov;
    case (s_code)
      0: begin r = x; s = y; end
      1: begin r = x; s = y; end
      2: begin r = 0; s = y; end
      3: begin r = 0; s = y; end
      4: begin r = 0; s = y; end
      5: begin r = x; s = y; end
      6: begin r = x; s = y; end
      default: begin r = x; s = 0; end
    endcase
    co = 0; ov = 0; xo = r; yo = s;
    if (f_code < 3) begin
      if (f_code == 1) begin xo = s; yo = r ^ 15; end
      if (f_code == 2) begin xo = r; yo = s ^ 15; end
      tot = xo + yo + c;
      res = tot & 15;
      co  = tot >> 4;
      ov  = (((xo >> 3) == (yo >> 3)) && (((res >> 3) & 1) != (xo >> 3))) ? 1 : 0;
    end else begin
      case (f_code)
        3: res = r | s;
        4: res = r & s;
        5: res = (r ^ 15) & s;
        6: res = r ^ s;
        default: res = (r ^ s) ^ 15;
      endcase
    end
    model4 = {co[0], ov[0], (res == 0), res[3], res[3:0]};
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    a4 = '0; b4 = '0; q4 = '0; d4 = '0; src = '0; fn = '0; cin = 1'b0;
    a32 = '0; b32 = '0; q32 = '0; d32 = '0; src32 = '0; fn32 = '0; cin32 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 idle state: all-zero inputs give a zero result
    check("R7 idle", {28'd0, co4, ov4, zr4, sg4, res4}, 36'h20);

    // R1..R10 exhaustive sweep at WIDTH=4
    for (int sc = 0; sc < 8; sc++)
      for (int fc = 0; fc < 8; fc++)
        for (int c = 0; c < 2; c++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
              @(negedge clk);
              src = sc[2:0]; fn = fc[2:0]; cin = c[0];
              d4 = x[3:0]; b4 = y[3:0]; q4 = y[3:0];
              a4 = (sc == 4 || sc == 5) ? y[3:0] : x[3:0];
              @(posedge clk);
              #1;
              check(fc == 0 ? "R1 R2 R6 R7 R8 R9" :
                    fc == 1 ? "R1 R3 R6 R7 R8 R9" :
                    fc == 2 ? "R1 R4 R6 R7 R8 R9" : "R1 R5 R6 R7 R10",
                    {28'd0, co4, ov4, zr4, sg4, res4}, {28'd0, model4(sc, fc, c, x, y)});
            end

    // WIDTH=32 boundaries, packed as {carry, overflow, zero, sign, result}
    @(negedge clk);
    src32 = 3'd1; fn32 = 3'd0; cin32 = 1'b0; a32 = 32'h7FFF_FFFF; b32 = 32'h1;
    @(posedge clk); #1;
    check("R8 32b signed add overflow", {co32, ov32, zr32, sg32, res32}, {4'b0101, 32'h8000_0000});
    @(negedge clk);
    a32 = 32'hFFFF_FFFF; b32 = 32'h0; cin32 = 1'b1;
    @(posedge clk); #1;
    check("R9 32b carry wrap to zero", {co32, ov32, zr32, sg32, res32}, {4'b1010, 32'h0});
    @(negedge clk);
    src32 = 3'd5; fn32 = 3'd2; d32 = 32'h8000_0000; a32 = 32'h1; cin32 = 1'b1;
    @(posedge clk); #1;
    check("R4 32b R minus S overflow", {co32, ov32, zr32, sg32, res32}, {4'b1100, 32'h7FFF_FFFF});
    @(negedge clk);
    src32 = 3'd6; fn32 = 3'd1; d32 = 32'h5; q32 = 32'h3; cin32 = 1'b0;
    @(posedge clk); #1;
    check("R3 32b S minus R borrow", {co32, ov32, zr32, sg32, res32}, {4'b0001, 32'hFFFF_FFFD});
    @(negedge clk);
    src32 = 3'd0; fn32 = 3'd5; a32 = 32'hF0F0_F0F0; q32 = 32'hFFFF_0000; cin32 = 1'b1;
    @(posedge clk); #1;
    check("R5 R10 32b masked and", {co32, ov32, zr32, sg32, res32}, {4'b0000, 32'h0F0F_0000});
    @(negedge clk);
    src32 = 3'd7; fn32 = 3'd7; d32 = 32'h0;
    @(posedge clk); #1;
    check("R5 R6 32b xnor with zero", {co32, ov32, zr32, sg32, res32}, {4'b0001, 32'hFFFF_FFFF});

    done = 1'b1;
    report();
  end
endmodule